// File: doc/BRIEF.md
# Three-Channel Compare-Match PWM Timer

This block contains three independent 16-bit timer channels. Each channel has a counter that advances on a shared count-enable strobe and two compare registers, A and B. When a channel is in PWM mode, its output pin goes high when the counter matches register A and low when it matches register B. When a channel is in normal mode, its output stays at 0.

Every match on register A sets a sticky flag for that channel. The flags and their interrupt enables share one 8-bit status/enable register. Software clears a flag by writing 0 to its bit. A channel requests an interrupt only while its flag and its enable are both set.

Software reaches the block through a single-cycle register bus. A write takes effect at the clock edge on which the write strobe is high. Reads are combinational from the address.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset, the registers read as follows: mode = 0x0000, status/enable = 0x0088, every counter = 0x0000, every A and B register = 0xFFFF. Every PWM output and every interrupt request is 0.
- R2: A counter advances by one at each clock edge where cnt_en is high, and holds its value otherwise. From 0xFFFF it wraps to 0x0000. A bus write to a counter loads the written value, and the write takes priority over counting.
- R3: A compare match on register A or B occurs on a clock edge where cnt_en is high and the counter's value before that edge equals the register.
- R4: In PWM mode (mode bit c = 1 for channel c), a B match drives pwm_out[c] to 0 and an A match alone drives it to 1. The output changes at the match edge. When A and B match on the same edge, the output goes to 0.
- R5: In normal mode (mode bit c = 0), pwm_out[c] is 0 from the edge after the mode bit is cleared, whatever matches occur.
- R6: An A match sets status bit c (the flag of channel c) in either mode.
- R7: Writing 0 to status bit c (c = 0..2) clears that flag. Writing 1 leaves it unchanged. If a match sets a flag on the same edge that a write clears it, the flag ends up set.
- R8: Status bits 6..4 are read/write interrupt enables for channels 2..0. Bits 7 and 3 always read 1 and ignore writes.
- R9: irq[c] is 1 exactly when flag c and enable c are both 1.
- R10: Register addresses are: mode at 0x0, status/enable at 0x1. For channel c, the counter is at 0x4+4c, register A at 0x5+4c and register B at 0x6+4c. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count-enable strobe shared by all channels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pwm_out | output | 3 | PWM output per channel |
| irq | output | 3 | Interrupt request per channel |

## Verification
The main test sweeps the A and B register values over every pair from 0 to 5, with each channel shifted to a different A value. Each pair is run with a count-enable pattern that has gaps in it. These runs separate A matches from B matches, coincident A/B matches, and missed matches on cycles where counting is disabled.

Directed cases cover the following:
- wrapping from 0xFFFF to 0x0000;
- a flag that is set by a match and cleared by a write on the same edge;
- writing 1 to a flag, which must have no effect;
- writes to the reserved bits;
- interrupt gating by the enable bits;
- matches that occur in normal mode.

// File: rtl/pwm_tmr_pkg.sv
// Package: address map and widths shared by the timer block and its bench.
// Assumes at most three channels, so that the flags and enables fit the 8-bit status image.
package pwm_tmr_pkg;
    localparam int ADDR_W     = 4;
    localparam int ADR_MODE   = 0;
    localparam int ADR_STAT   = 1;
    localparam int CH_BASE    = 4;
    localparam int CH_STRIDE  = 4;
    localparam int OFF_CNT    = 0;
    localparam int OFF_GRA    = 1;
    localparam int OFF_GRB    = 2;
    localparam int STAT_W     = 8;
    localparam int EN_LSB     = 4;
endpackage

// File: rtl/tmr_chan.sv
// Module: one timer channel. It holds a counter and compare registers A and B,
// detects matches and drives the PWM output from them.
// Assumes the write strobes are one-hot, coming from the top-level decoder.
module tmr_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          mode,
    input  logic          wr_cnt,
    input  logic          wr_gra,
    input  logic          wr_grb,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] gra_o,
    output logic [CW-1:0] grb_o,
    output logic          match_a_o,
    output logic          pwm_o
);
    localparam logic [CW-1:0] GR_INIT = '1;

    logic [CW-1:0] cnt_q, gra_q, grb_q;
    logic          pwm_q, match_a, match_b;

    // Compare against the counter value before this edge, only on count cycles.
    always_comb begin
        match_a = cnt_en && (cnt_q == gra_q);
        match_b = cnt_en && (cnt_q == grb_q);
    end

    // Counter: a bus write loads it; otherwise it advances on cnt_en and wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wdata;
        else if (cnt_en) cnt_q <= cnt_q + 1'b1;
    end

    // Compare registers: loaded only by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gra_q <= GR_INIT;
            grb_q <= GR_INIT;
        end else begin
            if (wr_gra) gra_q <= wdata;
            if (wr_grb) grb_q <= wdata;
        end
    end

    // PWM output: a B match clears it, an A match sets it, and normal mode holds it low.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode) pwm_q <= 1'b0;
        else if (match_b)    pwm_q <= 1'b0;
        else if (match_a)    pwm_q <= 1'b1;
    end

    assign cnt_o     = cnt_q;
    assign gra_o     = gra_q;
    assign grb_o     = grb_q;
    assign match_a_o = match_a;
    assign pwm_o     = pwm_q;

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !wr_cnt && (cnt_q == '1)) |=> (cnt_q == '0));
    a_r4_set_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && match_a && !match_b) |=> pwm_q);
    a_r4_clear_on_b: assert property (@(posedge clk) disable iff (!rst_n)
        (match_b) |=> !pwm_q);
    a_r5_normal_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode) |=> !pwm_q);
endmodule

// File: rtl/tmr_stat.sv
// Module: the flags and interrupt enables behind the shared status/enable register.
// Assumes NCH <= 3. Flags are cleared by writing zero; a hardware set wins over a clear on the same edge.
module tmr_stat #(
    parameter int NCH = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr,
    input  logic [pwm_tmr_pkg::STAT_W-1:0]    wdata,
    input  logic [NCH-1:0]                    set_i,
    output logic [NCH-1:0]                    flag_o,
    output logic [NCH-1:0]                    en_o,
    output logic [NCH-1:0]                    irq_o
);
    import pwm_tmr_pkg::*;

    logic [NCH-1:0] flag_q, en_q, flag_d;

    // Next flag value: a zero written to a bit clears it; a hardware set is ORed in last.
    always_comb begin
        flag_d = flag_q;
        if (wr) flag_d = flag_q & wdata[NCH-1:0];
        flag_d = flag_d | set_i;
    end

    // Flag and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= flag_d;
            if (wr) en_q <= wdata[EN_LSB +: NCH];
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;
    assign irq_o  = flag_q & en_q;

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && set_i == '0) |=> $stable(flag_q));
endmodule

// File: rtl/pwm_timer_top.sv
// Module: top level of the three-channel PWM timer. It holds the mode register,
// decodes the register bus and muxes read data.
// Assumes single-cycle writes and combinational reads.
module pwm_timer_top #(
    parameter int NCH = 3,
    parameter int CW  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cnt_en,
    input  logic                           bus_wr,
    input  logic [pwm_tmr_pkg::ADDR_W-1:0] bus_addr,
    input  logic [CW-1:0]                  bus_wdata,
    output logic [CW-1:0]                  bus_rdata,
    output logic [NCH-1:0]                 pwm_out,
    output logic [NCH-1:0]                 irq
);
    import pwm_tmr_pkg::*;

    logic [NCH-1:0]   mode_q, match_a, flag, en;
    logic [CW-1:0]    cnt_w [NCH];
    logic [CW-1:0]    gra_w [NCH];
    logic [CW-1:0]    grb_w [NCH];
    logic [STAT_W-1:0] stat_img;
    logic             wr_mode, wr_stat;

    assign wr_mode = bus_wr && (bus_addr == ADDR_W'(ADR_MODE));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));

    // Mode register: bit c selects PWM mode for channel c.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= bus_wdata[NCH-1:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * c;
        tmr_chan #(.CW(CW)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_en    (cnt_en),
            .mode      (mode_q[c]),
            .wr_cnt    (bus_wr && bus_addr == ADDR_W'(BASE + OFF_CNT)),
            .wr_gra    (bus_wr && bus_addr == ADDR_W'(BASE + OFF_GRA)),
            .wr_grb    (bus_wr && bus_addr == ADDR_W'(BASE + OFF_GRB)),
            .wdata     (bus_wdata),
            .cnt_o     (cnt_w[c]),
            .gra_o     (gra_w[c]),
            .grb_o     (grb_w[c]),
            .match_a_o (match_a[c]),
            .pwm_o     (pwm_out[c])
        );
    end

    tmr_stat #(.NCH(NCH)) stat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_stat),
        .wdata  (bus_wdata[STAT_W-1:0]),
        .set_i  (match_a),
        .flag_o (flag),
        .en_o   (en),
        .irq_o  (irq)
    );

    // Status image: reserved bits 7 and 3 read as one; flags sit in the low bits, enables above them.
    always_comb begin
        stat_img    = '0;
        stat_img[7] = 1'b1;
        stat_img[3] = 1'b1;
        stat_img[NCH-1:0]       = flag;
        stat_img[EN_LSB +: NCH] = en;
    end

    // Read mux: combinational from the address; unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_MODE)) bus_rdata = CW'(mode_q);
        if (bus_addr == ADDR_W'(ADR_STAT)) bus_rdata = CW'(stat_img);
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*c + OFF_CNT)) bus_rdata = cnt_w[c];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*c + OFF_GRA)) bus_rdata = gra_w[c];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*c + OFF_GRB)) bus_rdata = grb_w[c];
        end
    end
endmodule

// File: tb/pwm_timer_tb_top.sv
module pwm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  pwm_out, irq;
    int total = 0, bad = 0, cycles = 0;

    always #2 clk = ~clk;

    pwm_timer_top dut_i (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .irq(irq));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(addr); bus_wdata = 16'(data);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int addr, output logic [15:0] v);
        @(negedge clk);
        bus_addr = 4'(addr);
        #1 v = bus_rdata;
    endtask

    task automatic step(logic en);
        @(negedge clk);
        cnt_en = en;
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state; addresses per R10
        rd(0, v); check("R1 mode", v, 16'h0000);
        rd(1, v); check("R1 status", v, 16'h0088);
        for (int c = 0; c < 3; c++) begin
            rd(4 + 4*c, v); check("R1 counter", v, 16'h0000);
            rd(5 + 4*c, v); check("R1 regA", v, 16'hFFFF);
            rd(6 + 4*c, v); check("R1 regB", v, 16'hFFFF);
        end
        rd(3, v); check("R10 unmapped", v, 16'h0000);
        check("R1 pwm", pwm_out, 3'b000);
        check("R1 irq", irq, 3'b000);

        // Sweep over A/B pairs (R3 R4 R6)
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
                int cnt [3];
                int ga [3];
                logic [2:0] pw, fl;
                pw = '0; fl = '0;
                wr(0, 0);
                for (int c = 0; c < 3; c++) begin
                    cnt[c] = 0; ga[c] = (a + c) % 6;
                    wr(4 + 4*c, 0); wr(5 + 4*c, ga[c]); wr(6 + 4*c, b);
                end
                wr(1, 0);
                wr(0, 7);
                for (int s = 0; s < 8; s++) begin
                    logic e;
                    e = (s % 4) != 3;
                    step(e);
                    for (int c = 0; c < 3; c++) begin
                        if (e) begin
                            if (cnt[c] == b) pw[c] = 1'b0;
                            else if (cnt[c] == ga[c]) pw[c] = 1'b1;
                            if (cnt[c] == ga[c]) fl[c] = 1'b1;
                            cnt[c]++;
                        end
                    end
                    check("R4 pwm sweep", pwm_out, pw);
                end
                rd(1, v); check("R6 flags sweep", v, 16'h0088 | 16'(fl));
            end
        end

        // R2 wrap on channel 1
        wr(4 + 4*1, 16'hFFFF); wr(5 + 4*1, 0); wr(6 + 4*1, 5); wr(1, 0);
        step(1'b1);
        rd(8, v); check("R2 wrap to zero", v, 16'h0000);
        rd(1, v); check("R3 no match at FFFF", v, 16'h0088);
        step(1'b1);
        rd(1, v); check("R6 flag after wrap", v, 16'h008A);
        check("R4 pwm1 after A match", pwm_out[1], 1'b1);
        repeat (3) @(negedge clk);
        rd(8, v); check("R2 holds without cnt_en", v, 16'h0001);

        // R7 set wins over clear on the same edge
        wr(4, 0); wr(5, 0); wr(6, 9); wr(1, 0);
        @(negedge clk);
        cnt_en = 1'b1; bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 16'h0010;
        @(negedge clk);
        cnt_en = 1'b0; bus_wr = 1'b0;
        rd(1, v); check("R7 set wins", v, 16'h0099);
        check("R9 irq with flag and enable", irq, 3'b001);
        wr(1, 16'h0010);
        rd(1, v); check("R7 write zero clears", v, 16'h0098);
        check("R9 irq low after clear", irq, 3'b000);
        wr(1, 16'h0017);
        rd(1, v); check("R7 write one no effect", v, 16'h0098);
        wr(1, 16'h0000);
        rd(1, v); check("R8 reserved bits read one", v, 16'h0088);
        wr(1, 16'h0070);
        rd(1, v); check("R8 enables read back", v, 16'h00F8);

        // R9 gating: flag set with enable off, then on
        wr(1, 0);
        wr(4, 3); wr(5, 3);
        step(1'b1);
        check("R9 irq gated off", irq, 3'b000);
        wr(1, 16'h0011);
        check("R9 irq enabled", irq, 3'b001);

        // R4 coincident A and B match gives low
        wr(12, 2); wr(13, 2); wr(14, 9);
        step(1'b1);
        check("R4 pwm2 set", pwm_out[2], 1'b1);
        wr(13, 3); wr(14, 3);
        step(1'b1);
        check("R4 both match low", pwm_out[2], 1'b0);

        // R5 normal mode holds low; R6 flag still set
        wr(0, 0); wr(1, 0);
        wr(4, 0); wr(5, 0); wr(6, 7);
        step(1'b1);
        check("R5 normal mode pwm low", pwm_out, 3'b000);
        rd(1, v); check("R6 flag in normal mode", v, 16'h0089);
        rd(0, v); check("R10 mode readback", v, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule